// File: doc/BRIEF.md
# Instruction Fetch Breakpoint and Resume-Flag Unit

This unit compares every instruction fetch address against a small set of debug breakpoint address slots before the instruction is allowed to run. When an armed slot matches, it sends a debug fault request (vector 1, fault class) toward the exception sequencer one cycle later, together with one status bit per slot that matched. The sequencer then discards the instruction and delivers the fault.

The second job is the resume flag. While the flag is set, fetch breakpoints are suppressed, so the faulting instruction can be restarted once without faulting again. The unit computes the next flag value at each retirement. A normal completion clears the flag. A retirement that reloaded the flags itself (a flags pop, an interrupt return or a task switch) keeps the value that the instruction wrote. An aborted instruction leaves the flag as it is.

The unit does no address translation and does not hold the debug registers. The register file drives the slot addresses and the control word in, and it accumulates the status bits.

Top module: `ifetch_bp_unit`

## Requirements
- R1: After reset, `fault_req` is 0 and `hit_status` is all zeros.
- R2: A qualifying match on a fetch with `fetch_valid`=1 raises `fault_req` in the cycle after that fetch (one register stage). A single fetch gives a fault pulse exactly one cycle long.
- R3: Slot i is armed for fetch only when at least one of control bits 2i and 2i+1 is 1 and the two-bit type field at bits 16+4i and 17+4i is 00. Any nonzero type code (data or I/O kinds) makes the slot ignored for fetch.
- R4: Every armed slot whose address equals `fetch_addr` sets `hit_status[i]` in the same cycle as `fault_req`. Several bits can be set together. `fault_req` is 1 exactly when `hit_status` is nonzero.
- R5: When `rf_in`=1 during a fetch, neither `fault_req` nor any status bit is raised for that fetch.
- R6: When the low 2*NUM_SLOTS control bits are all zero, no breakpoint is reported for any address.
- R7: A retirement (`retire_valid`=1) with `retire_abort`=0 and `retire_keep_rf`=0 drives `rf_next` to 0 in the same cycle.
- R8: A retirement with `retire_keep_rf`=1 and no abort passes `rf_in` to `rf_next`. The qualifier covers only that retirement: a later retirement without it clears the flag.
- R9: An aborted retirement (`retire_abort`=1) passes `rf_in` to `rf_next` unchanged.
- R10: With `retire_valid`=0, `rf_next` equals `rf_in`.
- R11: The two length bits of each slot (18+4i, 19+4i) have no effect on fetch matching.
- R12: With `fetch_valid`=0, no fault and no status bit is raised, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | A fetch check is requested this cycle |
| fetch_addr | input | ADDR_W | Linear address of the instruction fetch |
| bp_addr | input | NUM_SLOTS*ADDR_W | Breakpoint addresses, slot i at bits [i*ADDR_W +: ADDR_W] |
| bp_ctrl | input | 16+4*NUM_SLOTS | Control word: enable pairs at bits 2i/2i+1, type at 16+4i, length at 18+4i |
| rf_in | input | 1 | Current resume flag |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_abort | input | 1 | The retiring instruction aborted |
| retire_keep_rf | input | 1 | The retiring instruction reloaded the flags itself |
| fault_req | output | 1 | Registered debug fault request to the exception sequencer |
| hit_status | output | NUM_SLOTS | Registered per-slot match bits for the faulting fetch |
| rf_next | output | 1 | Resume flag value after this cycle's retirement |

## Verification
An arming decode that reads the wrong bit would show up as a fault, or as a missing fault, on the first fetch after the control word changes. The sweep over every enable, type and length code for each slot exposes it within one cycle. A stuck or mis-gated fault register appears at `fault_req` and `hit_status` one cycle after the fetch, or as a pulse that lasts past the fetch. A resume-flag path with the wrong priority among abort, keep and retire gives a wrong `rf_next` in the same cycle, because that path has no state.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

  localparam int MAX_CTRL_W = 32;

  // Slot armed for instruction fetch: some enable bit set, type code zero.
  function automatic logic slot_armed(input logic [MAX_CTRL_W-1:0] ctrl, input int idx);
    logic [1:0] en_pair;
    logic [1:0] kind;
    en_pair = 2'(ctrl >> (2 * idx));
    kind    = 2'(ctrl >> (16 + 4 * idx));
    return (en_pair != 2'b00) && (kind == 2'b00);
  endfunction

  // Resume flag after a retirement slot in this cycle.
  function automatic logic rf_after_retire(input logic rf_cur, input logic ret,
                                           input logic abrt, input logic keep);
    if (ret && !abrt && !keep) return 1'b0;
    return rf_cur;
  endfunction

endpackage

// File: rtl/ibp_slot_match.sv
module ibp_slot_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic              armed,
  output logic              hit
);
  logic addr_eq;
  assign addr_eq = (fetch_addr == slot_addr);
  assign hit     = armed & addr_eq;
endmodule

// File: rtl/ibp_fault_reg.sv
module ibp_fault_reg #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 check_en,
  input  logic [NUM_SLOTS-1:0] hit_vec,
  output logic                 fault_req,
  output logic [NUM_SLOTS-1:0] hit_status
);
  logic [NUM_SLOTS-1:0] gated_hits;
  assign gated_hits = check_en ? hit_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_req  <= 1'b0;
      hit_status <= '0;
    end else begin
      fault_req  <= |gated_hits;
      hit_status <= gated_hits;
    end
  end

  // R4: the fault and the status bits always travel together
  p_status_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req == (hit_status != '0));

  // R2: a fault appears only after an enabled check
  p_fault_after_check_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !check_en |=> !fault_req);
endmodule

// File: rtl/ibp_rf_ctrl.sv
module ibp_rf_ctrl (
  input  logic rf_in,
  input  logic retire_valid,
  input  logic retire_abort,
  input  logic retire_keep_rf,
  output logic rf_next
);
  import ibp_pkg::*;
  assign rf_next = rf_after_retire(rf_in, retire_valid, retire_abort, retire_keep_rf);
endmodule

// File: rtl/ifetch_bp_unit.sv
module ifetch_bp_unit #(
  parameter int ADDR_W    = 32,
  parameter int NUM_SLOTS = 4,
  localparam int CTRL_W   = 16 + 4 * NUM_SLOTS,
  localparam int EN_W     = 2 * NUM_SLOTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fetch_valid,
  input  logic [ADDR_W-1:0]           fetch_addr,
  input  logic [NUM_SLOTS*ADDR_W-1:0] bp_addr,
  input  logic [CTRL_W-1:0]           bp_ctrl,
  input  logic                        rf_in,
  input  logic                        retire_valid,
  input  logic                        retire_abort,
  input  logic                        retire_keep_rf,
  output logic                        fault_req,
  output logic [NUM_SLOTS-1:0]        hit_status,
  output logic                        rf_next
);
  import ibp_pkg::*;

  logic [MAX_CTRL_W-1:0] ctrl_ext;
  logic [NUM_SLOTS-1:0]  armed_vec;
  logic [NUM_SLOTS-1:0]  raw_hit_vec;
  logic                  any_enable;
  logic                  check_en;

  assign ctrl_ext   = MAX_CTRL_W'(bp_ctrl);
  assign any_enable = |bp_ctrl[EN_W-1:0];
  assign check_en   = fetch_valid & ~rf_in & any_enable;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign armed_vec[i] = slot_armed(ctrl_ext, i);
    ibp_slot_match #(.ADDR_W(ADDR_W)) u_match (
      .fetch_addr (fetch_addr),
      .slot_addr  (bp_addr[i*ADDR_W +: ADDR_W]),
      .armed      (armed_vec[i]),
      .hit        (raw_hit_vec[i])
    );

    // R4: a status bit names a slot whose address equalled the fetch
    p_hit_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit_status[i]) |-> $past(fetch_addr) == $past(bp_addr[i*ADDR_W +: ADDR_W]));
  end

  ibp_fault_reg #(.NUM_SLOTS(NUM_SLOTS)) u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .check_en   (check_en),
    .hit_vec    (raw_hit_vec),
    .fault_req  (fault_req),
    .hit_status (hit_status)
  );

  ibp_rf_ctrl u_rf (
    .rf_in          (rf_in),
    .retire_valid   (retire_valid),
    .retire_abort   (retire_abort),
    .retire_keep_rf (retire_keep_rf),
    .rf_next        (rf_next)
  );

  // R5: resume flag suppresses the fault of that fetch
  p_rf_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && rf_in |=> !fault_req);

  // R6: no enable bit at all means no report
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bp_ctrl[EN_W-1:0] == '0 |=> hit_status == '0);

  // R12: no fetch, no fault
  p_no_fetch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !fault_req);

  // R9: an aborted instruction leaves the flag alone
  p_rf_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && retire_abort |-> rf_next == rf_in);

  // R7: a plain completion clears the flag
  p_rf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && !retire_abort && !retire_keep_rf |-> !rf_next);
endmodule

// File: tb/sim_ifetch_bp_unit.sv
module sim_ifetch_bp_unit;
  localparam int AW = 32;
  localparam int NS = 4;
  localparam int CW = 16 + 4 * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [NS*AW-1:0] bp_addr = '0;
  logic [CW-1:0] bp_ctrl = '0;
  logic          rf_in = 1'b0;
  logic          retire_valid = 1'b0;
  logic          retire_abort = 1'b0;
  logic          retire_keep_rf = 1'b0;
  logic          fault_req;
  logic [NS-1:0] hit_status;
  logic          rf_next;

  int total = 0;
  int bad = 0;
  logic [AW-1:0] slot_a [NS];

  always #10 clk = ~clk;

  ifetch_bp_unit #(.ADDR_W(AW), .NUM_SLOTS(NS)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_addrs();
    for (int k = 0; k < NS; k++) bp_addr[k*AW +: AW] = slot_a[k];
  endtask

  // one fetch; outputs sampled after the registering edge
  task automatic fetch(input logic [AW-1:0] a, input logic v);
    @(negedge clk);
    fetch_valid = v;
    fetch_addr  = a;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NS; k++) slot_a[k] = 32'h4000_0000 + k * 32'h0001_0110;
    load_addrs();
    #35;
    chk("R1 fault", {31'b0, fault_req}, 0);
    chk("R1 status", {28'b0, hit_status}, 0);
    rst_n = 1'b1;

    // R3/R11/R4: every enable pair, type and length code for each slot
    for (int i = 0; i < NS; i++) begin
      for (int en = 0; en < 4; en++) begin
        for (int cfg = 0; cfg < 16; cfg++) begin
          logic exp_f;
          @(negedge clk);
          bp_ctrl = CW'((en << (2 * i)) | (cfg << (16 + 4 * i)));
          exp_f = (en != 0) && ((cfg % 4) == 0);
          fetch(slot_a[i], 1'b1);
          chk("R3 R11 fault", {31'b0, fault_req}, {31'b0, exp_f});
          chk("R4 status", {28'b0, hit_status}, exp_f ? (32'd1 << i) : 0);
          fetch(slot_a[i] + 1, 1'b1);
          chk("R4 mismatch", {31'b0, fault_req}, 0);
          idle();
        end
      end
    end

    // R2: pulse one cycle long
    @(negedge clk); bp_ctrl = CW'(32'h0000_0002);
    fetch(slot_a[0], 1'b1);
    chk("R2 raise", {31'b0, fault_req}, 1);
    idle(); @(posedge clk); #1;
    chk("R2 one cycle", {31'b0, fault_req}, 0);

    // R4: several slots at one address
    for (int k = 0; k < NS; k++) slot_a[k] = 32'h0000_7C00;
    load_addrs();
    @(negedge clk); bp_ctrl = CW'(32'h0000_00FF);
    fetch(32'h0000_7C00, 1'b1);
    chk("R4 all", {28'b0, hit_status}, 32'hF);
    @(negedge clk); bp_ctrl = CW'(32'h0000_00FF | (1 << (16 + 8)));
    fetch(32'h0000_7C00, 1'b1);
    chk("R4 R3 typed slot2", {28'b0, hit_status}, 32'hB);

    // R5: resume flag suppresses
    @(negedge clk); rf_in = 1'b1;
    fetch(32'h0000_7C00, 1'b1);
    chk("R5 fault", {31'b0, fault_req}, 0);
    chk("R5 status", {28'b0, hit_status}, 0);
    @(negedge clk); rf_in = 1'b0;

    // R6: all enables zero, types zero, many addresses
    @(negedge clk); bp_ctrl = CW'(32'h0000_FF00);
    for (int t = 0; t < 8; t++) begin
      fetch(32'h0000_7C00 + t, 1'b1);
      chk("R6", {31'b0, fault_req}, 0);
    end

    // R12: no fetch strobe
    @(negedge clk); bp_ctrl = CW'(32'h0000_00FF);
    fetch(32'h0000_7C00, 1'b0);
    chk("R12", {31'b0, fault_req}, 0);
    idle();

    // R7/R8/R9/R10: every combination of the retire inputs
    for (int c = 0; c < 16; c++) begin
      logic e;
      @(negedge clk);
      rf_in          = c[0];
      retire_valid   = c[1];
      retire_abort   = c[2];
      retire_keep_rf = c[3];
      #1;
      e = (c[1] && !c[2] && !c[3]) ? 1'b0 : c[0];
      chk("R7 R8 R9 R10 rf_next", {31'b0, rf_next}, {31'b0, e});
    end

    // R8: keep applies to one retirement only
    @(negedge clk);
    rf_in = 1'b1; retire_valid = 1'b1; retire_abort = 1'b0; retire_keep_rf = 1'b1;
    #1; chk("R8 kept", {31'b0, rf_next}, 1);
    @(negedge clk); retire_keep_rf = 1'b0;
    #1; chk("R8 next clears", {31'b0, rf_next}, 0);
    @(negedge clk); retire_valid = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule